// File: doc/BRIEF.md
# Region-Based Access Permission Checker

This block decides whether a bus access may proceed. It holds a table of memory region descriptors. Each descriptor has a start bound, an end bound, a valid bit and one permission word that covers eight bus masters. Every access presents an address, the number of the requesting master, the access kind (read, write or instruction fetch) and whether the master is in supervisor or user mode. The checker compares the address with every valid region in parallel. It returns a single allow/deny decision, the number of regions that matched, and a flag that is set when the address falls in more than one region.

The four low-numbered masters have a three-bit user rights field and a two-bit supervisor code. The supervisor code can grant fixed rights or fall back to the user rights. The four high-numbered masters have only a read enable and a write enable. A simple write port loads the bounds, permission words, region valid bits and a global enable. That port also protects region 0 from master 0: master 0 cannot move region 0's bounds or change the rights held there by master 1, so master 1 keeps access to that region.

Top module: `region_guard`

## Requirements
- R1: After reset the global enable and every region valid bit are clear. Every access is allowed, `hit_count` is 0 and `multi_hit` is 0.
- R2: Bounds have 32-byte granularity. The low 5 bits of a written start bound are taken as zero and those of a written end bound as ones. A region matches an address when start <= address <= end, both ends included.
- R3: A region whose valid bit is clear never matches. `hit_count` gives the number of valid regions that match the access address, and `multi_hit` is 1 exactly when that number is 2 or more.
- R4: When the global enable is clear every access is allowed. When it is set, an access that matches no region is denied.
- R5: For master m in 0..3, the rights field sits at bits [6m+5:6m] of the permission word. Bits [6m+2:6m] are the user rights: bit 6m+2 is read, bit 6m+1 is write and bit 6m is execute, and each bit grants its kind independently. In user mode these bits decide the access.
- R6: For master m in 0..3, bits [6m+4:6m+3] are the supervisor code, which decides in supervisor mode. Code 0 grants read, write and execute. Code 1 grants read and execute. Code 2 grants read and write. Code 3 uses the user bits. Bit 6m+5 is stored and has no effect.
- R7: For master 4+k (k = 0..3), bit 24+2k is the write enable and bit 25+2k is the read enable. A read or an instruction fetch needs the read enable and a write needs the write enable. Privilege mode has no effect.
- R8: When several valid regions match, the access is allowed if at least one of them grants the needed right.
- R9: A write from master 0 to region 0 leaves the start bound, the end bound and permission bits [11:6] (master 1's field) unchanged. The other permission bits of that write still take effect.
- R10: Write-port kinds: 0 = start bound, 1 = end bound, 2 = permission word, 3 = region valid (data bit 0), 4 = global enable (data bit 0); other kinds are ignored. A write takes effect on the clock edge where `wr_en` is high and shows in the outputs from the following cycle on. Writes from any master other than master 0, including master 1's writes to region 0, are not restricted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Descriptor write strobe |
| wr_master | input | 3 | Master issuing the write |
| wr_region | input | clog2(NUM_REGIONS) | Region addressed by the write |
| wr_kind | input | 3 | Which descriptor item is written (see R10) |
| wr_data | input | max(ADDR_W,32) | Write data |
| acc_addr | input | ADDR_W | Address of the access under check |
| acc_master | input | 3 | Master making the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 instruction fetch; 3 is never granted by a region |
| acc_priv | input | 1 | 1 supervisor, 0 user |
| acc_allow | output | 1 | Access is permitted |
| hit_count | output | clog2(NUM_REGIONS+1) | Number of valid regions matching the address |
| multi_hit | output | 1 | More than one region matched |

## Verification
The hardest case to reach from the ports is the region 0 lock. It only takes effect when master 0 writes, and a locked field looks the same as an updated one unless the old and new values lead to different decisions. The bench first has master 1 set region 0 to a narrow range and a read-only field for master 1. Master 0 then writes a wider start and end and an all-ones permission word. The bench probes addresses just inside and just outside the original bounds, and checks a write by master 1 that is denied only if its field survived. It also checks that master 0's own field was updated. Overlap is checked with two regions that grant different rights to the same master, so that allow depends on combining their grants.

// File: rtl/rg_pkg.sv
package rg_pkg;

  localparam int PERM_W      = 32;
  localparam int LOW_FLD_W   = 6;
  localparam int HIGH_BASE   = 24;
  localparam int CORE_MASTER = 0;
  localparam int DBG_MASTER  = 1;

  typedef enum logic [2:0] {
    WK_START  = 3'd0,
    WK_END    = 3'd1,
    WK_PERM   = 3'd2,
    WK_VALID  = 3'd3,
    WK_GLOBAL = 3'd4
  } wr_kind_e;

  typedef enum logic [1:0] {
    AK_READ  = 2'd0,
    AK_WRITE = 2'd1,
    AK_EXEC  = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/rg_desc_store.sv
module rg_desc_store
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  parameter int DATA_W      = 32,
  parameter int RIDX_W      = 3,
  parameter int BLK_W       = ADDR_W - GRAN_BITS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                wr_en,
  input  logic [2:0]                          wr_master,
  input  logic [RIDX_W-1:0]                   wr_region,
  input  logic [2:0]                          wr_kind,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic [NUM_REGIONS-1:0][BLK_W-1:0]   start_blk_o,
  output logic [NUM_REGIONS-1:0][BLK_W-1:0]   end_blk_o,
  output logic [NUM_REGIONS-1:0][PERM_W-1:0]  perm_o,
  output logic [NUM_REGIONS-1:0]              valid_o,
  output logic                                glb_en_o
);

  localparam int          DBG_LO   = LOW_FLD_W * DBG_MASTER;
  localparam logic [PERM_W-1:0] DBG_MASK = {{(PERM_W-LOW_FLD_W){1'b0}}, {LOW_FLD_W{1'b1}}} << DBG_LO;

  logic [NUM_REGIONS-1:0][BLK_W-1:0]  start_q, start_d;
  logic [NUM_REGIONS-1:0][BLK_W-1:0]  end_q,   end_d;
  logic [NUM_REGIONS-1:0][PERM_W-1:0] perm_q,  perm_d;
  logic [NUM_REGIONS-1:0]             valid_q, valid_d;
  logic                               glb_q,   glb_d;

  logic     region_ok;
  logic     lock_r0;
  wr_kind_e kind;

  assign kind      = wr_kind_e'(wr_kind);
  assign region_ok = int'(wr_region) < NUM_REGIONS;
  assign lock_r0   = (int'(wr_master) == CORE_MASTER) && (wr_region == '0);

  // next-state
  always_comb begin
    start_d = start_q;
    end_d   = end_q;
    perm_d  = perm_q;
    valid_d = valid_q;
    glb_d   = glb_q;
    if (region_ok) begin
      unique case (kind)
        WK_START: if (!lock_r0) start_d[wr_region] = wr_data[ADDR_W-1:GRAN_BITS];
        WK_END:   if (!lock_r0) end_d[wr_region]   = wr_data[ADDR_W-1:GRAN_BITS];
        WK_PERM: begin
          if (lock_r0)
            perm_d[wr_region] = (wr_data[PERM_W-1:0] & ~DBG_MASK) | (perm_q[wr_region] & DBG_MASK);
          else
            perm_d[wr_region] = wr_data[PERM_W-1:0];
        end
        WK_VALID:  valid_d[wr_region] = wr_data[0];
        WK_GLOBAL: glb_d = wr_data[0];
        default: ;
      endcase
    end else if (kind == WK_GLOBAL) begin
      glb_d = wr_data[0];
    end
  end

  // registers, clock-enabled by the write strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      end_q   <= '0;
      perm_q  <= '0;
      valid_q <= '0;
      glb_q   <= 1'b0;
    end else if (wr_en) begin
      start_q <= start_d;
      end_q   <= end_d;
      perm_q  <= perm_d;
      valid_q <= valid_d;
      glb_q   <= glb_d;
    end
  end

  assign start_blk_o = start_q;
  assign end_blk_o   = end_q;
  assign perm_o      = perm_q;
  assign valid_o     = valid_q;
  assign glb_en_o    = glb_q;

  AST_R0_START_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_START && lock_r0) |=> $stable(start_q[0])); // R9
  AST_R0_END_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_END && lock_r0) |=> $stable(end_q[0])); // R9
  AST_DBG_FIELD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_PERM && lock_r0) |=> $stable(perm_q[0][DBG_LO +: LOW_FLD_W])); // R9
  AST_PERM_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && kind == WK_PERM && region_ok && !lock_r0)
      |=> perm_q[$past(wr_region)] == $past(wr_data[PERM_W-1:0])); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(perm_q) && $stable(valid_q) && $stable(glb_q))); // R10

endmodule

// File: rtl/rg_perm_decode.sv
module rg_perm_decode
  import rg_pkg::*;
(
  input  logic [PERM_W-1:0] perm,
  input  logic [2:0]        master,
  input  logic [1:0]        kind,
  input  logic              priv,
  output logic              grant
);

  logic [LOW_FLD_W-1:0] fld;
  logic [2:0]           usr_rwx;
  logic [2:0]           sup_rwx;
  logic [2:0]           eff_rwx;
  logic [1:0]           hi_rw;
  int                   lo_base;
  int                   hi_base;
  acc_kind_e            k;

  assign k = acc_kind_e'(kind);

  always_comb begin
    lo_base = LOW_FLD_W * int'(master[1:0]);
    hi_base = HIGH_BASE + 2 * int'(master[1:0]);
    fld     = perm[lo_base +: LOW_FLD_W];
    hi_rw   = perm[hi_base +: 2];
    usr_rwx = fld[2:0];
    unique case (fld[4:3])
      2'd0:    sup_rwx = 3'b111;
      2'd1:    sup_rwx = 3'b101;
      2'd2:    sup_rwx = 3'b110;
      default: sup_rwx = usr_rwx;
    endcase
    eff_rwx = priv ? sup_rwx : usr_rwx;
    grant   = 1'b0;
    if (!master[2]) begin
      unique case (k)
        AK_READ:  grant = eff_rwx[2];
        AK_WRITE: grant = eff_rwx[1];
        AK_EXEC:  grant = eff_rwx[0];
        default:  grant = 1'b0;
      endcase
    end else begin
      unique case (k)
        AK_READ, AK_EXEC: grant = hi_rw[1];
        AK_WRITE:         grant = hi_rw[0];
        default:          grant = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/rg_region_match.sv
module rg_region_match
  import rg_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 5,
  parameter int BLK_W     = ADDR_W - GRAN_BITS
) (
  input  logic [BLK_W-1:0]  start_blk,
  input  logic [BLK_W-1:0]  end_blk,
  input  logic              valid,
  input  logic [PERM_W-1:0] perm,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_master,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              hit,
  output logic              grant
);

  logic [BLK_W-1:0] addr_blk;
  logic             rights_ok;

  assign addr_blk = acc_addr[ADDR_W-1:GRAN_BITS];
  assign hit      = valid && (addr_blk >= start_blk) && (addr_blk <= end_blk);

  rg_perm_decode u_decode (
    .perm   (perm),
    .master (acc_master),
    .kind   (acc_kind),
    .priv   (acc_priv),
    .grant  (rights_ok)
  );

  assign grant = hit && rights_ok;

endmodule

// File: rtl/region_guard.sv
module region_guard
  import rg_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 5,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
  localparam int HCNT_W     = $clog2(NUM_REGIONS + 1),
  localparam int DATA_W     = (ADDR_W > PERM_W) ? ADDR_W : PERM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_master,
  input  logic [RIDX_W-1:0] wr_region,
  input  logic [2:0]        wr_kind,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [2:0]        acc_master,
  input  logic [1:0]        acc_kind,
  input  logic              acc_priv,
  output logic              acc_allow,
  output logic [HCNT_W-1:0] hit_count,
  output logic              multi_hit
);

  localparam int BLK_W = ADDR_W - GRAN_BITS;

  logic [NUM_REGIONS-1:0][BLK_W-1:0]  start_blk;
  logic [NUM_REGIONS-1:0][BLK_W-1:0]  end_blk;
  logic [NUM_REGIONS-1:0][PERM_W-1:0] perm;
  logic [NUM_REGIONS-1:0]             valid;
  logic                               glb_en;
  logic [NUM_REGIONS-1:0]             hit_vec;
  logic [NUM_REGIONS-1:0]             grant_vec;
  logic [HCNT_W-1:0]                  cnt;

  rg_desc_store #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W),
    .GRAN_BITS   (GRAN_BITS),
    .DATA_W      (DATA_W),
    .RIDX_W      (RIDX_W)
  ) u_store (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_master   (wr_master),
    .wr_region   (wr_region),
    .wr_kind     (wr_kind),
    .wr_data     (wr_data),
    .start_blk_o (start_blk),
    .end_blk_o   (end_blk),
    .perm_o      (perm),
    .valid_o     (valid),
    .glb_en_o    (glb_en)
  );

  for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
    rg_region_match #(
      .ADDR_W    (ADDR_W),
      .GRAN_BITS (GRAN_BITS)
    ) u_match (
      .start_blk  (start_blk[g]),
      .end_blk    (end_blk[g]),
      .valid      (valid[g]),
      .perm       (perm[g]),
      .acc_addr   (acc_addr),
      .acc_master (acc_master),
      .acc_kind   (acc_kind),
      .acc_priv   (acc_priv),
      .hit        (hit_vec[g]),
      .grant      (grant_vec[g])
    );

    AST_INVALID_NEVER_HITS: assert property (@(posedge clk) disable iff (!rst_n)
      !valid[g] |-> !hit_vec[g]); // R3
  end

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      cnt = cnt + HCNT_W'(hit_vec[i]);
    end
  end

  assign hit_count = cnt;
  assign multi_hit = (cnt > HCNT_W'(1));
  assign acc_allow = !glb_en || (|grant_vec);

  AST_GLOBAL_OFF_ALLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |-> acc_allow); // R4
  AST_NO_HIT_DENIES: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && hit_count == '0) |-> !acc_allow); // R4
  AST_ALLOW_HAS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (glb_en && acc_allow) |-> (hit_count != '0)); // R8

endmodule

// File: tb/region_guard_bench.sv
`timescale 1ns/1ps
module region_guard_bench;

  localparam int NR = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [2:0]  wr_master;
  logic [2:0]  wr_region;
  logic [2:0]  wr_kind;
  logic [31:0] wr_data;
  logic [31:0] acc_addr;
  logic [2:0]  acc_master;
  logic [1:0]  acc_kind;
  logic        acc_priv;
  logic        acc_allow;
  logic [3:0]  hit_count;
  logic        multi_hit;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  region_guard #(.NUM_REGIONS(NR)) u_region_guard (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_master  (wr_master),
    .wr_region  (wr_region),
    .wr_kind    (wr_kind),
    .wr_data    (wr_data),
    .acc_addr   (acc_addr),
    .acc_master (acc_master),
    .acc_kind   (acc_kind),
    .acc_priv   (acc_priv),
    .acc_allow  (acc_allow),
    .hit_count  (hit_count),
    .multi_hit  (multi_hit)
  );

  localparam logic [2:0] K_START = 3'd0, K_END = 3'd1, K_PERM = 3'd2, K_VALID = 3'd3, K_GLOBAL = 3'd4;
  localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

  task automatic wr(input logic [2:0] m, input logic [2:0] r, input logic [2:0] k, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_master = m; wr_region = r; wr_kind = k; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [2:0] m, input logic [1:0] k,
                       input logic p, input logic exp_allow, input int exp_cnt, input logic exp_multi);
    acc_addr = a; acc_master = m; acc_kind = k; acc_priv = p;
    #1;
    checks++;
    if (acc_allow !== exp_allow || int'(hit_count) != exp_cnt || multi_hit !== exp_multi) begin
      fails++;
      $display("FAIL %s addr=%h m=%0d k=%0d p=%0d: allow/hits/multi actual %b/%0d/%b expected %b/%0d/%b",
               tag, a, m, k, p, acc_allow, hit_count, multi_hit, exp_allow, exp_cnt, exp_multi);
    end
  endtask

  task automatic t_reset;
    probe("R1 reset", 32'h0000_1000, 3'd2, WR, 1'b0, 1'b1, 0, 1'b0);
    probe("R1 reset", 32'hFFFF_FFE0, 3'd6, EX, 1'b1, 1'b1, 0, 1'b0);
  endtask

  task automatic t_setup_invalid;
    wr(3'd1, 3'd0, K_GLOBAL, 32'h1);
    wr(3'd1, 3'd1, K_START, 32'h0000_1010);
    wr(3'd1, 3'd1, K_END,   32'h0000_1FE0);
    wr(3'd1, 3'd1, K_PERM,  32'h0621_C011);
    probe("R3 invalid region", 32'h0000_1000, 3'd2, RD, 1'b0, 1'b0, 0, 1'b0);
    probe("R4 no hit denies",  32'h0000_1000, 3'd4, RD, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_latency;
    @(negedge clk);
    wr_en = 1'b1; wr_master = 3'd1; wr_region = 3'd1; wr_kind = K_VALID; wr_data = 32'h1;
    probe("R10 before edge", 32'h0000_1000, 3'd2, RD, 1'b0, 1'b0, 0, 1'b0);
    @(negedge clk);
    wr_en = 1'b0;
    probe("R10 after edge", 32'h0000_1000, 3'd2, RD, 1'b0, 1'b1, 1, 1'b0);
  endtask

  task automatic t_granularity;
    probe("R2 below start", 32'h0000_0FFF, 3'd2, RD, 1'b0, 1'b0, 0, 1'b0);
    probe("R2 start block", 32'h0000_1000, 3'd2, RD, 1'b0, 1'b1, 1, 1'b0);
    probe("R2 end block",   32'h0000_1FFF, 3'd2, RD, 1'b0, 1'b1, 1, 1'b0);
    probe("R2 above end",   32'h0000_2000, 3'd2, RD, 1'b0, 1'b0, 0, 1'b0);
  endtask

  task automatic t_user_rights;
    probe("R5 m2 user read",  32'h0000_1400, 3'd2, RD, 1'b0, 1'b1, 1, 1'b0);
    probe("R5 m2 user write", 32'h0000_1400, 3'd2, WR, 1'b0, 1'b0, 1, 1'b0);
    probe("R5 m2 user exec",  32'h0000_1400, 3'd2, EX, 1'b0, 1'b0, 1, 1'b0);
    probe("R5 m0 user exec",  32'h0000_1400, 3'd0, EX, 1'b0, 1'b1, 1, 1'b0);
    probe("R5 m0 user read",  32'h0000_1400, 3'd0, RD, 1'b0, 1'b0, 1, 1'b0);
  endtask

  task automatic t_super_rights;
    probe("R6 m0 sup2 read",  32'h0000_1400, 3'd0, RD, 1'b1, 1'b1, 1, 1'b0);
    probe("R6 m0 sup2 write", 32'h0000_1400, 3'd0, WR, 1'b1, 1'b1, 1, 1'b0);
    probe("R6 m0 sup2 exec",  32'h0000_1400, 3'd0, EX, 1'b1, 1'b0, 1, 1'b0);
    probe("R6 m2 sup3 read",  32'h0000_1400, 3'd2, RD, 1'b1, 1'b1, 1, 1'b0);
    probe("R6 m2 sup3 write", 32'h0000_1400, 3'd2, WR, 1'b1, 1'b0, 1, 1'b0);
    probe("R6 m3 sup1 exec",  32'h0000_1400, 3'd3, EX, 1'b1, 1'b1, 1, 1'b0);
    probe("R6 m3 sup1 write", 32'h0000_1400, 3'd3, WR, 1'b1, 1'b0, 1, 1'b0);
    probe("R6 m3 user read",  32'h0000_1400, 3'd3, RD, 1'b0, 1'b0, 1, 1'b0);
  endtask

  task automatic t_high_masters;
    probe("R7 m4 read",  32'h0000_1400, 3'd4, RD, 1'b0, 1'b1, 1, 1'b0);
    probe("R7 m4 exec",  32'h0000_1400, 3'd4, EX, 1'b1, 1'b1, 1, 1'b0);
    probe("R7 m4 write", 32'h0000_1400, 3'd4, WR, 1'b1, 1'b0, 1, 1'b0);
    probe("R7 m5 write", 32'h0000_1400, 3'd5, WR, 1'b0, 1'b1, 1, 1'b0);
    probe("R7 m5 read",  32'h0000_1400, 3'd5, RD, 1'b0, 1'b0, 1, 1'b0);
    probe("R7 m5 exec",  32'h0000_1400, 3'd5, EX, 1'b1, 1'b0, 1, 1'b0);
  endtask

  task automatic t_overlap;
    wr(3'd1, 3'd2, K_START, 32'h0000_1800);
    wr(3'd1, 3'd2, K_END,   32'h0000_27FF);
    wr(3'd1, 3'd2, K_PERM,  32'h0001_A000);
    wr(3'd1, 3'd2, K_VALID, 32'h1);
    probe("R8 write via region2", 32'h0000_1800, 3'd2, WR, 1'b0, 1'b1, 2, 1'b1);
    probe("R8 read via region1",  32'h0000_1800, 3'd2, RD, 1'b0, 1'b1, 2, 1'b1);
    probe("R8 exec neither",      32'h0000_1800, 3'd2, EX, 1'b0, 1'b0, 2, 1'b1);
    probe("R3 single hit",        32'h0000_2100, 3'd2, RD, 1'b1, 1'b0, 1, 1'b0);
    probe("R3 single hit write",  32'h0000_2100, 3'd2, WR, 1'b0, 1'b1, 1, 1'b0);
  endtask

  task automatic t_region0_lock;
    wr(3'd1, 3'd0, K_START, 32'h0000_0000);
    wr(3'd1, 3'd0, K_END,   32'h0000_00FF);
    wr(3'd1, 3'd0, K_PERM,  32'h0000_0700);
    wr(3'd1, 3'd0, K_VALID, 32'h1);
    probe("R10 m1 sets region0", 32'h0000_0000, 3'd0, RD, 1'b0, 1'b0, 1, 1'b0);
    wr(3'd0, 3'd0, K_START, 32'h0000_0040);
    wr(3'd0, 3'd0, K_END,   32'h0000_07FF);
    wr(3'd0, 3'd0, K_PERM,  32'hFFFF_FFFF);
    probe("R9 start kept",       32'h0000_0000, 3'd0, WR, 1'b0, 1'b1, 1, 1'b0);
    probe("R9 end kept",         32'h0000_0100, 3'd0, RD, 1'b0, 1'b0, 0, 1'b0);
    probe("R9 m1 field kept",    32'h0000_0020, 3'd1, WR, 1'b0, 1'b0, 1, 1'b0);
    probe("R9 m1 still reads",   32'h0000_0020, 3'd1, RD, 1'b0, 1'b1, 1, 1'b0);
    probe("R9 m6 field updated", 32'h0000_0020, 3'd6, WR, 1'b0, 1'b1, 1, 1'b0);
    wr(3'd1, 3'd0, K_END, 32'h0000_01FF);
    probe("R10 m1 moves end",    32'h0000_0100, 3'd0, RD, 1'b0, 1'b1, 1, 1'b0);
  endtask

  task automatic t_ignored_kind;
    wr(3'd1, 3'd1, 3'd6, 32'h0);
    probe("R10 unused kind ignored", 32'h0000_1400, 3'd2, RD, 1'b0, 1'b1, 1, 1'b0);
  endtask

  task automatic t_global_off;
    wr(3'd1, 3'd0, K_GLOBAL, 32'h0);
    probe("R4 global off no hit", 32'h0000_5000, 3'd2, WR, 1'b0, 1'b1, 0, 1'b0);
    probe("R4 global off denied kind", 32'h0000_1400, 3'd2, WR, 1'b0, 1'b1, 1, 1'b0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_master = '0; wr_region = '0; wr_kind = '0; wr_data = '0;
    acc_addr = '0; acc_master = '0; acc_kind = '0; acc_priv = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_invalid();
    t_latency();
    t_granularity();
    t_user_rights();
    t_super_rights();
    t_high_masters();
    t_overlap();
    t_region0_lock();
    t_ignored_kind();
    t_global_off();
    done = 1;
    finish_run();
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

endmodule